// File: doc/BRIEF.md
# Segmented Error-Tolerant Unsigned Multiplier

This block is a purely combinational unsigned multiplier that trades accuracy in the low-order product bits for a smaller multiplier array. Each N-bit operand is cut into a high segment of N-K bits and a low segment of K bits. A single exact multiplier, sized for the wider of the two segments, is shared between two operating modes. The high segments of both operands are reduced by a NOR to pick the mode.

When both high segments are zero, the operands are small. The shared array then multiplies the two low segments exactly, and the product is exact.

When either high segment is non-zero, the array multiplies the two high segments, and that product is placed at bit offset 2K. The bottom K product bits are filled by a carry-free approximation of the low segments:

- The low segments are scanned from their top bit downward.
- Each result bit is the OR of the two operand bits.
- At the first position where both bits are 1, that bit and every bit below it are forced to 1.
- The cross terms are dropped, so product bits K to 2K-1 are always zero in this mode.

Typical use is in error-tolerant datapaths such as filtering, where large operands dominate the result.

Top module: `split_approx_mul`

## Requirements
- R1: When bits [N-1:K] of both operands are all zero, prod_o equals the exact product opa_i*opb_i, zero-extended to 2N bits.
- R2: When either operand has a non-zero bit in [N-1:K], prod_o[2N-1:2K] equals opa_i[N-1:K]*opb_i[N-1:K].
- R3: When either operand has a non-zero bit in [N-1:K], prod_o[2K-1:K] is all zero.
- R4: In the mode of R2, prod_o[i] for i<K equals opa_i[i] | opb_i[i] at every position i that lies above the highest position j<K where opa_i[j] and opb_i[j] are both 1.
- R5: In the mode of R2, prod_o[j] and every bit below j are 1, where j is the highest position below K with opa_i[j]=opb_i[j]=1.
- R6: In the mode of R2, when no position below K has both operand bits set, prod_o[K-1:0] equals opa_i[K-1:0] | opb_i[K-1:0].
- R7: In the mode of R2, a zero operand does not force a zero product: prod_o[K-1:0] carries the other operand's low segment, and the upper fields are zero.
- R8: All of R1 to R7 hold when the segments have unequal widths (N-K different from K).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | N | First unsigned operand |
| opb_i | input | N | Second unsigned operand |
| prod_o | output | 2N | Exact or approximate product |

## Verification
Both modes are swept over every operand pair of two 8-bit configurations: one with equal segments and one with a 5/3 split. Together these cover every mode boundary and every position of the first common set bit.

- A mode detector that reduced only one operand would give approximate results for small-times-large pairs that ought to be exact, or the reverse.
- A fill that scans from the wrong end, or forces only the common bit, would corrupt the low field below the first common 1.
- A zero operand paired with a large one is checked on its own. A design that short-circuits zero would lose the non-zero low field that this mode defines.
- The unequal split catches a shared array or output concatenation sized from K alone.

// File: rtl/seg_mul_pkg.sv
package seg_mul_pkg;
  typedef enum logic {
    MODE_LO_EXACT  = 1'b0,
    MODE_HI_APPROX = 1'b1
  } seg_mode_e;

  function automatic int unsigned seg_max(input int unsigned x, input int unsigned y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/seg_mul_zero_det.sv
module seg_mul_zero_det #(
  parameter int unsigned H = 8
) (
  input  logic [H-1:0] a_hi_i,
  input  logic [H-1:0] b_hi_i,
  output logic         both_zero_o
);
  assign both_zero_o = ~(|{a_hi_i, b_hi_i});
endmodule

// File: rtl/seg_mul_lo_fill.sv
module seg_mul_lo_fill #(
  parameter int unsigned K = 8
) (
  input  logic [K-1:0] a_lo_i,
  input  logic [K-1:0] b_lo_i,
  output logic [K-1:0] fill_o
);
  logic seen;
  // top-down scan: once both bits are 1, saturate the rest
  always_comb begin
    seen   = 1'b0;
    fill_o = '0;
    for (int i = K - 1; i >= 0; i--) begin
      seen      = seen | (a_lo_i[i] & b_lo_i[i]);
      fill_o[i] = seen | a_lo_i[i] | b_lo_i[i];
    end
  end
endmodule

// File: rtl/seg_mul_array.sv
module seg_mul_array #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned PW = 2 * W;
  logic [PW-1:0] acc;
  always_comb begin
    acc = '0;
    for (int r = 0; r < W; r++) begin
      if (b_i[r]) acc = acc + (PW'(a_i) << r);
    end
  end
  assign p_o = acc;
endmodule

// File: rtl/split_approx_mul.sv
module split_approx_mul
  import seg_mul_pkg::*;
#(
  parameter int unsigned N = 16,
  parameter int unsigned K = 8
) (
  input  logic [N-1:0]   opa_i,
  input  logic [N-1:0]   opb_i,
  output logic [2*N-1:0] prod_o
);
  localparam int unsigned H  = N - K;
  localparam int unsigned M  = seg_max(H, K);
  localparam int unsigned PW = 2 * N;

  logic [H-1:0]   a_hi, b_hi;
  logic [K-1:0]   a_lo, b_lo, lo_fill;
  logic           hi_zero;
  seg_mode_e      mode;
  logic [M-1:0]   core_a, core_b;
  logic [2*M-1:0] core_p;

  assign a_hi = opa_i[N-1:K];
  assign b_hi = opb_i[N-1:K];
  assign a_lo = opa_i[K-1:0];
  assign b_lo = opb_i[K-1:0];

  seg_mul_zero_det #(.H(H)) u_zdet (
    .a_hi_i      (a_hi),
    .b_hi_i      (b_hi),
    .both_zero_o (hi_zero)
  );

  assign mode = hi_zero ? MODE_LO_EXACT : MODE_HI_APPROX;

  // one shared exact array, fed by whichever segment pair the mode selects
  assign core_a = (mode == MODE_LO_EXACT) ? M'(a_lo) : M'(a_hi);
  assign core_b = (mode == MODE_LO_EXACT) ? M'(b_lo) : M'(b_hi);

  seg_mul_array #(.W(M)) u_core (
    .a_i (core_a),
    .b_i (core_b),
    .p_o (core_p)
  );

  seg_mul_lo_fill #(.K(K)) u_fill (
    .a_lo_i (a_lo),
    .b_lo_i (b_lo),
    .fill_o (lo_fill)
  );

  always_comb begin
    if (mode == MODE_LO_EXACT) prod_o = PW'(core_p);
    else                       prod_o = {core_p[2*H-1:0], K'(0), lo_fill};
  end
endmodule

// File: rtl/split_approx_mul_chk.sv
module split_approx_mul_chk #(
  parameter int unsigned N = 16,
  parameter int unsigned K = 8
) (
  input logic [N-1:0]   opa_i,
  input logic [N-1:0]   opb_i,
  input logic [2*N-1:0] prod_o
);
  localparam int unsigned H  = N - K;
  localparam int unsigned PW = 2 * N;
  localparam int unsigned HW = 2 * H;

  logic [H-1:0]  ah, bh;
  logic [K-1:0]  al, bl;
  logic [PW-1:0] full;
  logic [HW-1:0] hh;

  assign ah   = opa_i[N-1:K];
  assign bh   = opb_i[N-1:K];
  assign al   = opa_i[K-1:0];
  assign bl   = opb_i[K-1:0];
  assign full = PW'(opa_i) * PW'(opb_i);
  assign hh   = HW'(ah) * HW'(bh);

  always_comb begin
    if (!$isunknown({opa_i, opb_i, prod_o})) begin
      if (ah == '0 && bh == '0) begin
        assert_exact_low_R1: assert (prod_o == full)
          else $error("R1 exact-low product mismatch");
      end else begin
        assert_hi_field_R2: assert (prod_o[PW-1:2*K] == hh)
          else $error("R2 high field mismatch");
        assert_mid_zero_R3: assert (prod_o[2*K-1:K] == '0)
          else $error("R3 cross-term field not zero");
        assert_lsb_set_R5: assert (((al & bl) == '0) || prod_o[0])
          else $error("R5 saturation missing at bit 0");
        assert_or_fill_R6: assert (((al & bl) != '0) || (prod_o[K-1:0] == (al | bl)))
          else $error("R6 low field not OR of segments");
      end
    end
  end
endmodule

bind split_approx_mul split_approx_mul_chk #(.N(N), .K(K)) u_chk (
  .opa_i  (opa_i),
  .opb_i  (opb_i),
  .prod_o (prod_o)
);

// File: tb/split_approx_mul_test.sv
`timescale 1ns/1ps
module split_approx_mul_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0]  a8, b8, a3, b3;
  logic [15:0] p8, p3;
  logic [15:0] aw, bw;
  logic [31:0] pw;

  split_approx_mul #(.N(8), .K(4)) uut (.opa_i(a8), .opb_i(b8), .prod_o(p8));
  split_approx_mul #(.N(8), .K(3)) uut_odd (.opa_i(a3), .opb_i(b3), .prod_o(p3));
  split_approx_mul uut_wide (.opa_i(aw), .opb_i(bw), .prod_o(pw));

  function automatic logic [31:0] ref_prod(int k, logic [15:0] a, logic [15:0] b);
    logic [15:0] ah, bh, al, bl, msk;
    logic [31:0] f;
    logic seen;
    msk = 16'((32'd1 << k) - 1);
    al = a & msk;
    bl = b & msk;
    ah = a >> k;
    bh = b >> k;
    if (ah == 0 && bh == 0) return 32'(a) * 32'(b);
    seen = 1'b0;
    f = '0;
    for (int i = k - 1; i >= 0; i--) begin
      if (al[i] & bl[i]) seen = 1'b1;
      if (seen | al[i] | bl[i]) f[i] = 1'b1;
    end
    return ((32'(ah) * 32'(bh)) << (2 * k)) | f;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(int k, logic [15:0] a, logic [15:0] b);
    logic [15:0] msk;
    msk = 16'((32'd1 << k) - 1);
    if ((a >> k) == 0 && (b >> k) == 0) return "R1";
    if ((a & b & msk) == 0) return "R6";
    return "R5";
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    a8 = '0; b8 = '0; a3 = '0; b3 = '0; aw = '0; bw = '0;
    @(negedge clk);
    check("R1 zero inputs", {16'h0, p8}, 32'h0);
    check("R1 zero inputs wide", pw, 32'h0);

    // exhaustive sweep, 4/4 split and 5/3 split (R8)
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        @(posedge clk);
        a8 = 8'(a); b8 = 8'(b); a3 = 8'(a); b3 = 8'(b);
        @(negedge clk);
        check(tag_of(4, 16'(a), 16'(b)), {16'h0, p8}, ref_prod(4, 16'(a), 16'(b)));
        check({"R8 ", tag_of(3, 16'(a), 16'(b))}, {16'h0, p3}, ref_prod(3, 16'(a), 16'(b)));
      end
    end

    // directed, default 16/8 configuration
    @(posedge clk); aw = 16'h00FF; bw = 16'h00FF;
    @(negedge clk); check("R1 max small", pw, 32'd65025);
    @(posedge clk); aw = 16'h0100; bw = 16'h0100;
    @(negedge clk); check("R2 unit high", pw, 32'h0001_0000);
    @(posedge clk); aw = 16'hFFFF; bw = 16'hFFFF;
    @(negedge clk);
    check("R2 all ones", pw, 32'hFE01_00FF);
    check("R3 middle zero", {24'h0, pw[15:8]}, 32'h0);
    @(posedge clk); aw = 16'h0188; bw = 16'h0148;
    @(negedge clk); check("R4 or above common", pw, 32'h0001_00CF);
    @(posedge clk); aw = 16'h1234; bw = 16'h5678;
    @(negedge clk); check("R5 saturate below", pw, 32'h060C_007F);
    @(posedge clk); aw = 16'h01A0; bw = 16'h0150;
    @(negedge clk); check("R6 no common", pw, 32'h0001_00F0);
    @(posedge clk); aw = 16'h0000; bw = 16'hAB12;
    @(negedge clk); check("R7 zero operand", pw, 32'h0000_0012);
    @(posedge clk); aw = 16'hAB12; bw = 16'h0000;
    @(negedge clk); check("R7 zero operand swapped", pw, 32'h0000_0012);
    @(posedge clk); aw = 16'h8001; bw = 16'h0001;
    @(negedge clk); check("R5 common at bit0", pw, 32'h0000_0001);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule